// File: doc/BRIEF.md
# Synchronous Link Flag Hunter and Zero-Deletion Receiver

This block is the receive front end of a bit-oriented synchronous link. It takes one serial bit per cycle in which `bit_en` is high, hunts for the frame delimiter `01111110`, and locks onto frame boundaries. Inside a frame it deletes the zeros the sender inserted after runs of ones. It tells apart three cases: a deleted zero, a closing or opening delimiter, and an abort, which is a run of seven ones. The delivered bits are packed into octets and leave on a byte stream with one-cycle `out_valid` pulses, marked with start-of-frame and end-of-frame.

The delimiter bits never reach the byte stream. To achieve this, the last few received data bits wait in a short hold line and are committed only once it is certain they are not part of a delimiter. The last complete octet of each frame is also held back by one octet, so that end-of-frame can sit on the octet itself. A frame whose length is not a whole number of octets ends with a misalignment mark. An aborted frame ends with an abort mark, and the receiver then hunts for a delimiter again. Frame check and header parsing belong to later stages.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is 0 and the receiver is hunting.
- R2: While hunting (after reset or after an abort), no beat is produced whatever bits arrive, until a `01111110` delimiter has been received.
- R3: `bit_in` is sampled only in cycles with `bit_en` high. A beat appears as a single-cycle `out_valid` pulse in the cycle after the sampled bit that caused it, and every mark output is 0 when `out_valid` is 0.
- R4: Inside a frame, a 0 that follows exactly five consecutive 1s is deleted and contributes no data bit.
- R5: Data bits are packed first-received into bit 0 of `out_data`, up to bit 7.
- R6: Delimiter bits are never delivered. A frame of N whole octets yields exactly N beats, carrying the sent octets in order.
- R7: The first beat of a frame has `out_sof`=1. On a closing delimiter with no leftover bits, the last complete octet carries `out_eof`=1. No second `out_sof` appears before an `out_eof`.
- R8: A closing delimiter with 1 to 7 leftover bits ends the frame with a beat marked `out_eof`=1 and `out_misalign`=1. That beat carries the last complete octet, or 0 if there is none.
- R9: Seven consecutive 1s inside a frame with at least one committed bit produce an end beat with `out_eof`=1 and `out_abort`=1, carrying the oldest uncommitted octet (0 if none). The receiver then returns to hunting.
- R10: Two delimiters with no data between them, including two that share a 0, produce no beat, and the second delimiter opens the next frame.
- R11: `out_abort` and `out_misalign` are never high together, and each occurs only on a beat with `out_eof`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial line bit |
| out_valid | output | 1 | One-cycle beat strobe |
| out_data | output | BYTE_W | Received octet, first bit in bit 0 |
| out_sof | output | 1 | Beat is the first of a frame |
| out_eof | output | 1 | Beat is the last of a frame |
| out_abort | output | 1 | Frame ended by an abort run |
| out_misalign | output | 1 | Frame ended with a partial octet |

## Verification
The bound checker watches, on every cycle, the way beats are framed. Each beat follows a sampled bit, and marks appear only on beats. Start and end alternate properly. Abort and misalignment appear only on an end beat, and an abort leaves the receiver hunting. No beat comes from a receiver that is not inside a frame. Whether the right octets come out is something only the bench scenarios can show. It depends on zero deletion, on stripping the delimiters, on bit order, on the misalignment and abort payloads, and on silence while hunting. For these the bench stuffs known payloads itself and compares the captured beats.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   typedef enum logic [1:0] {
      SYM_DATA  = 2'd0,
      SYM_STUFF = 2'd1,
      SYM_FLAG  = 2'd2,
      SYM_ABORT = 2'd3
   } sym_e;
endpackage

// File: rtl/hdlc_rx_symclass.sv
module hdlc_rx_symclass
   import hdlc_rx_pkg::*;
#(
   parameter int RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   output sym_e sym
);
   localparam int RUN_MAX = RUN + 2;
   localparam int RUN_W   = $clog2(RUN_MAX + 1);

   logic [RUN_W-1:0] run_q;

   // classify the current bit against the ones seen before it
   always_comb begin
      if (bit_in) begin
         sym = (run_q >= RUN_W'(RUN + 1)) ? SYM_ABORT : SYM_DATA;
      end else if (run_q == RUN_W'(RUN)) begin
         sym = SYM_STUFF;
      end else if (run_q == RUN_W'(RUN + 1)) begin
         sym = SYM_FLAG;
      end else begin
         sym = SYM_DATA;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (bit_en) begin
         if (!bit_in) begin
            run_q <= '0;
         end else if (run_q != RUN_W'(RUN_MAX)) begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_holdline.sv
module hdlc_rx_holdline #(
   parameter int DEPTH = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic clear,
   input  logic din,
   output logic commit_v,
   output logic commit_bit
);
   localparam int FILL_W = $clog2(DEPTH + 1);

   logic [DEPTH-1:0]  line_q;
   logic [FILL_W-1:0] fill_q;

   // the oldest bit leaves only once the line is full
   assign commit_v   = push && (fill_q == FILL_W'(DEPTH));
   assign commit_bit = line_q[DEPTH-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
         fill_q <= '0;
      end else if (clear) begin
         fill_q <= '0;
      end else if (push) begin
         line_q <= {line_q[DEPTH-2:0], din};
         if (fill_q != FILL_W'(DEPTH)) begin
            fill_q <= fill_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_octet.sv
module hdlc_rx_octet
   import hdlc_rx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  sym_e              sym,
   input  logic              commit_v,
   input  logic              commit_bit,
   output logic              in_frame,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_abort,
   output logic              out_misalign
);
   localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;

   logic [BYTE_W-1:0] acc_q, acc_nx, pend_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              pend_v, started;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign acc_nx = {commit_bit, acc_q[BYTE_W-1:1]};
      end else begin : g_msb
         assign acc_nx = {acc_q[BYTE_W-2:0], commit_bit};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame     <= 1'b0;
         acc_q        <= '0;
         pend_q       <= '0;
         cnt_q        <= '0;
         pend_v       <= 1'b0;
         started      <= 1'b0;
         out_valid    <= 1'b0;
         out_data     <= '0;
         out_sof      <= 1'b0;
         out_eof      <= 1'b0;
         out_abort    <= 1'b0;
         out_misalign <= 1'b0;
      end else begin
         out_valid    <= 1'b0;
         out_sof      <= 1'b0;
         out_eof      <= 1'b0;
         out_abort    <= 1'b0;
         out_misalign <= 1'b0;
         if (step) begin
            unique case (sym)
               SYM_FLAG: begin
                  if (in_frame && (pend_v || cnt_q != '0)) begin
                     out_valid    <= 1'b1;
                     out_sof      <= !started;
                     out_eof      <= 1'b1;
                     out_misalign <= (cnt_q != '0);
                     out_data     <= pend_v ? pend_q : '0;
                  end
                  in_frame <= 1'b1;
                  pend_v   <= 1'b0;
                  cnt_q    <= '0;
                  started  <= 1'b0;
               end
               SYM_ABORT: begin
                  if (in_frame && (pend_v || cnt_q != '0 || started)) begin
                     out_valid <= 1'b1;
                     out_sof   <= !started;
                     out_eof   <= 1'b1;
                     out_abort <= 1'b1;
                     out_data  <= pend_v ? pend_q : '0;
                  end
                  in_frame <= 1'b0;
                  pend_v   <= 1'b0;
                  cnt_q    <= '0;
                  started  <= 1'b0;
               end
               default: begin
                  if (commit_v) begin
                     acc_q <= acc_nx;
                     if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                        cnt_q  <= '0;
                        pend_q <= acc_nx;
                        pend_v <= 1'b1;
                        if (pend_v) begin
                           out_valid <= 1'b1;
                           out_sof   <= !started;
                           out_data  <= pend_q;
                           started   <= 1'b1;
                        end
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int STUFF_RUN = 5,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              bit_in,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_abort,
   output logic              out_misalign
);
   // a delimiter leaves a leading zero plus one more one than the stuffing run
   localparam int HOLD_DEPTH = STUFF_RUN + 2;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must be at least 2");
      end
      if (STUFF_RUN < 2) begin : g_bad_run
         $error("STUFF_RUN must be at least 2");
      end
   endgenerate

   sym_e sym;
   logic frm_open, push, clear, commit_v, commit_bit;

   assign push  = bit_en && frm_open && (sym == SYM_DATA);
   assign clear = !frm_open || (bit_en && (sym == SYM_FLAG || sym == SYM_ABORT));

   hdlc_rx_symclass #(.RUN(STUFF_RUN)) u_cls (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .bit_in (bit_in),
      .sym    (sym)
   );

   hdlc_rx_holdline #(.DEPTH(HOLD_DEPTH)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .clear      (clear),
      .din        (bit_in),
      .commit_v   (commit_v),
      .commit_bit (commit_bit)
   );

   hdlc_rx_octet #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_oct (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (bit_en),
      .sym          (sym),
      .commit_v     (commit_v),
      .commit_bit   (commit_bit),
      .in_frame     (frm_open),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .out_sof      (out_sof),
      .out_eof      (out_eof),
      .out_abort    (out_abort),
      .out_misalign (out_misalign)
   );
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic frm_open,
   input logic out_valid,
   input logic out_sof,
   input logic out_eof,
   input logic out_abort,
   input logic out_misalign
);
   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (out_valid) begin
         open_q <= !out_eof;
      end
   end

   p_beat_follows_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(bit_en));

   p_marks_need_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(out_sof || out_eof || out_abort || out_misalign));

   p_beat_from_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(frm_open));

   p_sof_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sof) |-> !open_q);

   p_mid_beat_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sof) |-> open_q);

   p_term_on_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_abort || out_misalign) |-> (out_valid && out_eof));

   p_term_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_abort && out_misalign));

   p_abort_hunts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_abort) |-> !frm_open);
endmodule

bind hdlc_rx_deframer hdlc_rx_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bit_en       (bit_en),
   .frm_open     (frm_open),
   .out_valid    (out_valid),
   .out_sof      (out_sof),
   .out_eof      (out_eof),
   .out_abort    (out_abort),
   .out_misalign (out_misalign)
);

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
   localparam int CLK_P = 10;
   localparam int NV    = 4;
   localparam logic [31:0] VEC_DATA [NV] = '{32'hF83FFF7E, 32'h00000000, 32'h0000FFFF, 32'h00A53412};
   localparam int          VEC_LEN  [NV] = '{4, 1, 2, 3};

   logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
   logic       out_valid, out_sof, out_eof, out_abort, out_misalign;
   logic [7:0] out_data;

   int checks = 0, failures = 0, tx_ones = 0, ncap = 0;
   logic [7:0] cap_d [32];
   logic [3:0] cap_f [32];   // {sof, eof, abort, misalign}

   always #(CLK_P/2) clk = ~clk;

   hdlc_rx_deframer u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
      .out_eof(out_eof), .out_abort(out_abort), .out_misalign(out_misalign)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && ncap < 32) begin
         cap_d[ncap] = out_data;
         cap_f[ncap] = {out_sof, out_eof, out_abort, out_misalign};
         ncap = ncap + 1;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); bit_en = 1'b1; bit_in = b;
      @(negedge clk); bit_en = 1'b0; bit_in = 1'($urandom);
   endtask

   task automatic send_flag();
      send_bit(0);
      for (int i = 0; i < 6; i++) send_bit(1);
      send_bit(0);
      tx_ones = 0;
   endtask

   // sender-side zero insertion after five ones
   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         send_bit(v[i]);
         if (v[i]) begin
            tx_ones++;
            if (tx_ones == 5) begin send_bit(0); tx_ones = 0; end
         end else tx_ones = 0;
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic chk_beat(input string req, input int idx, input logic [7:0] d, input logic [3:0] f);
      chk(req, $sformatf("beat%0d data", idx), int'(cap_d[idx]), int'(d));
      chk(req, $sformatf("beat%0d marks", idx), int'(cap_f[idx]), int'(f));
   endtask

   initial begin
      #(CLK_P * 150000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset holds outputs low
      chk("R1", "valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "outputs after reset",
          int'({out_valid, out_sof, out_eof, out_abort, out_misalign, out_data}), 0);

      // R2: junk before any delimiter is ignored
      ncap = 0;
      for (int i = 0; i < 40; i++) send_bit(i % 3 == 0);
      settle();
      chk("R2", "beats while hunting", ncap, 0);

      // R4 R5 R6 R7: table of stuffed payloads
      for (int v = 0; v < NV; v++) begin
         ncap = 0;
         send_flag();
         for (int k = 0; k < VEC_LEN[v]; k++) send_byte(VEC_DATA[v][8*k +: 8]);
         send_flag();
         settle();
         chk("R6", $sformatf("vec%0d beat count", v), ncap, VEC_LEN[v]);
         for (int k = 0; k < VEC_LEN[v]; k++)
            chk_beat("R7", k, VEC_DATA[v][8*k +: 8], {k == 0, k == VEC_LEN[v] - 1, 2'b00});
      end

      // R3: long run of ones with bit_en low changes nothing
      ncap = 0;
      send_flag();
      send_byte(8'h3C);
      @(negedge clk); bit_in = 1'b1;
      repeat (20) @(negedge clk);
      send_byte(8'hC3);
      send_flag();
      settle();
      chk("R3", "beats with gaps", ncap, 2);
      chk_beat("R3", 0, 8'h3C, 4'b1000);
      chk_beat("R3", 1, 8'hC3, 4'b0100);

      // R10: back-to-back and shared-zero delimiters produce nothing
      ncap = 0;
      send_flag(); send_flag(); send_flag();
      for (int i = 0; i < 6; i++) send_bit(1);
      send_bit(0);
      send_byte(8'h81);
      send_flag();
      settle();
      chk("R10", "beats after shared zero", ncap, 1);
      chk_beat("R10", 0, 8'h81, 4'b1100);

      // R8: 12 bits then delimiter
      ncap = 0;
      send_flag();
      send_byte(8'h96);
      send_bit(1); send_bit(0); send_bit(1); send_bit(0);
      send_flag();
      settle();
      chk("R8", "misalign count", ncap, 1);
      chk_beat("R8", 0, 8'h96, 4'b1101);

      // R8: only 3 bits
      ncap = 0;
      send_flag();
      send_bit(1); send_bit(1); send_bit(0);
      send_flag();
      settle();
      chk("R8", "short count", ncap, 1);
      chk_beat("R8", 0, 8'h00, 4'b1101);

      // R9: abort after three octets, then hunting ignores data (R2)
      ncap = 0;
      send_flag();
      send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h00);
      for (int i = 0; i < 7; i++) send_bit(1);
      send_bit(0);
      send_byte(8'h55); send_byte(8'h24);
      settle();
      chk("R9", "abort beats", ncap, 2);
      chk_beat("R9", 0, 8'hA5, 4'b1000);
      chk_beat("R9", 1, 8'h3C, 4'b0110);

      // R2 R9: recovery on next delimiter
      ncap = 0;
      send_flag();
      send_byte(8'h5A);
      send_flag();
      settle();
      chk("R2", "recovery count", ncap, 1);
      chk_beat("R2", 0, 8'h5A, 4'b1100);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule